// File: doc/BRIEF.md
# Page-Buffered Parallel EEPROM Front End

This block is a clocked model of the control logic of a byte-alterable parallel nonvolatile memory. The host drives active-low chip enable, output enable and write enable, an address and a data bus. The bus is split on chip into an input byte, an output byte and a drive enable. The host can read the storage array, write one byte, or load several bytes of one page into a page buffer. A timed programming cycle then copies the loaded bytes into the array.

The control inputs and a supply-good flag pass through two flip-flop stages before any edge is detected. The address and data are delayed by the same two stages so that they stay aligned with the controls. A write cycle is the span during which chip enable and write enable are both low while output enable is high. The address is taken when that span opens, and the data is the last byte seen before it closes. A load stays open while each new write starts within a window of the previous accepted one. When the window lapses, programming starts on its own. During programming the busy output is high and new writes are ignored.

The page size, address width, stored page count, window length, programming length and minimum write pulse are all parameters in clock cycles.

Top module: `pbee_ctrl`

## Requirements
- R1: The data output is driven (`dq_oe`=1, `dq_o` = stored byte) only while `ce_n`=0, `oe_n`=0 and `vcc_ok`=1. Otherwise `dq_oe`=0. A never-programmed byte reads as 8'hFF.
- R2: A write cycle needs `ce_n`=0 and `we_n`=0 with `oe_n`=1. Holding `oe_n`=0 during that time writes nothing and starts no programming.
- R3: The address is captured when the later of `ce_n`/`we_n` falls. The data is the value on `dq_i` just before the earlier of them rises. This holds for write-enable-controlled and chip-enable-controlled cycles alike.
- R4: All bytes accepted into one load are committed together in a single programming cycle. Other bytes of the same page keep their old content. The storage holds 2^STORE_PAGE_W pages; the page field is `addr[ADDR_W-1:PAGE_W]`, and the offset is `addr[PAGE_W-1:0]`.
- R5: During a load, a byte whose page field differs from the first byte's is ignored. It is not stored and it does not restart the window.
- R6: A load stays open while each accepted write starts within LOAD_WIN cycles of the previous accepted write's start. Programming begins on its own once the window lapses with no write in progress.
- R7: `busy` is high for exactly PROG_CYC cycles per programming cycle. The new data is readable after `busy` falls. Writes made while `busy` is high are ignored.
- R8: A write cycle lasting fewer than MIN_LOW cycles is ignored. One lasting MIN_LOW cycles or more is accepted.
- R9: While `vcc_ok`=0, reads do not drive the bus and writes are ignored.
- R10: After reset, `busy`=0 and `dq_oe`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_ok | input | 1 | Supply-good flag; low blocks all functions |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| dq_i | input | 8 | Data bus as seen by the block |
| dq_o | output | 8 | Read data |
| dq_oe | output | 1 | Bus drive enable (bus floats when low) |
| busy | output | 1 | Programming cycle in progress |

## Verification
Single bytes are written both under write-enable control and under chip-enable control. In the chip-enable case the address and data change inside the cycle, which shows whether capture happens at the correct edges. Multi-byte loads with retriggering gaps show the window being extended, and the bytes left unwritten show that the rest of the page is untouched. A foreign-page byte placed late in a load shows it neither lands nor delays programming. Write pulses of one cycle below and exactly at the minimum, writes with output enable low, writes during busy and accesses with the supply flag low each separate an accepted write from a blocked one.

// File: rtl/pbee_pkg.sv
package pbee_pkg;
  localparam int DATA_W = 8;
  typedef logic [DATA_W-1:0] byte_t;

  // Width of a counter that must reach the value `limit`.
  function automatic int cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

  // Storage index from page number and offset (the page number is already truncated).
  function automatic int unsigned store_index(input int unsigned page, input int unsigned off,
                                              input int unsigned page_w);
    return (page << page_w) | off;
  endfunction
endpackage

// File: rtl/pbee_sync.sv
module pbee_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/pbee_wrcap.sv
module pbee_wrcap
  import pbee_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int MIN_LOW  = 3,
  parameter int LOAD_WIN = 25000,
  parameter int AGE_W    = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_ns,
  input  logic              oe_ns,
  input  logic              we_ns,
  input  logic              vcc_s,
  input  logic [ADDR_W-1:0] addr_a,
  input  byte_t             data_a,
  output logic              wr_act,
  output logic              wr_start,
  output logic              wr_done,
  output logic [ADDR_W-1:0] wr_addr,
  output byte_t             wr_data,
  output logic [AGE_W-1:0]  wr_age
);
  localparam int LOW_W = cnt_width(MIN_LOW);
  localparam logic [LOW_W-1:0] LOW_LIM = LOW_W'(MIN_LOW);
  localparam logic [AGE_W-1:0] AGE_LIM = AGE_W'(LOAD_WIN);

  logic             act_q;
  logic [LOW_W-1:0] low_cnt;
  logic             wr_end;

  assign wr_act   = !ce_ns && !we_ns && oe_ns && vcc_s;
  assign wr_start = wr_act && !act_q;
  assign wr_end   = act_q && !wr_act;
  // Abort when the cycle ends because output enable fell or the supply dropped.
  assign wr_done  = wr_end && oe_ns && vcc_s && (low_cnt >= LOW_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      low_cnt <= '0;
      wr_age  <= '0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      act_q <= wr_act;
      if (wr_start) begin
        wr_addr <= addr_a;
        low_cnt <= LOW_W'(1);
      end else if (wr_act && low_cnt != LOW_LIM) begin
        low_cnt <= low_cnt + 1'b1;
      end
      if (wr_act) wr_data <= data_a;
      if (wr_start) wr_age <= AGE_W'(1);
      else if (wr_age != AGE_LIM) wr_age <= wr_age + 1'b1;
    end
  end

  // R3
  addr_at_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> (wr_addr == $past(addr_a)));
  // R3
  data_at_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> (wr_data == $past(data_a)));
endmodule

// File: rtl/pbee_page.sv
module pbee_page
  import pbee_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int PAGE_W       = 8,
  parameter int STORE_PAGE_W = 2,
  parameter int LOAD_WIN     = 25000,
  parameter int PROG_CYC     = 1250000,
  parameter int AGE_W        = 15,
  parameter int STORE_W      = STORE_PAGE_W + PAGE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_act,
  input  logic               wr_done,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  byte_t              wr_data,
  input  logic [AGE_W-1:0]   wr_age,
  input  logic [STORE_W-1:0] rd_idx,
  output byte_t              rd_byte,
  output logic               busy
);
  localparam int PAGE_BYTES  = 1 << PAGE_W;
  localparam int PG_W        = ADDR_W - PAGE_W;
  localparam int STORE_BYTES = 1 << STORE_W;
  localparam int PROG_W      = cnt_width(PROG_CYC);
  localparam logic [PROG_W-1:0] PROG_LAST = PROG_W'(PROG_CYC - 1);
  localparam logic [AGE_W-1:0]  WIN_LIM   = AGE_W'(LOAD_WIN);

  byte_t                  mem     [STORE_BYTES];
  byte_t                  pbuf    [PAGE_BYTES];
  logic [PAGE_BYTES-1:0]  vmask;
  logic                   loading;
  logic [PG_W-1:0]        page_base;
  logic [AGE_W-1:0]       win_cnt;
  logic [PROG_W-1:0]      prog_cnt;

  logic [PG_W-1:0]   wr_page;
  logic [PAGE_W-1:0] wr_off;
  logic              page_hit, byte_acc, byte_reject, win_expire, prog_done;

  assign wr_page     = wr_addr[ADDR_W-1:PAGE_W];
  assign wr_off      = wr_addr[PAGE_W-1:0];
  assign page_hit    = (wr_page == page_base);
  assign byte_acc    = wr_done && !busy && (!loading || page_hit);
  assign byte_reject = wr_done && !busy && loading && !page_hit;
  assign win_expire  = loading && !wr_act && !wr_done && (win_cnt >= WIN_LIM);
  assign prog_done   = busy && (prog_cnt == PROG_LAST);
  assign rd_byte     = mem[rd_idx];

  // Load side: page buffer, valid mask and retriggering window.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loading   <= 1'b0;
      page_base <= '0;
      win_cnt   <= '0;
      vmask     <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= '0;
    end else begin
      if (byte_acc) begin
        pbuf[wr_off]  <= wr_data;
        vmask[wr_off] <= 1'b1;
        win_cnt       <= wr_age;
        if (!loading) begin
          loading   <= 1'b1;
          page_base <= wr_page;
        end
      end else if (win_expire) begin
        loading <= 1'b0;
      end else if (loading && win_cnt != WIN_LIM) begin
        win_cnt <= win_cnt + 1'b1;
      end
      if (prog_done) vmask <= '0;
    end
  end

  // Programming side: timed cycle, commit at its last cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      prog_cnt <= '0;
      for (int i = 0; i < STORE_BYTES; i++) mem[i] <= 8'hFF;
    end else begin
      if (win_expire) begin
        busy     <= 1'b1;
        prog_cnt <= '0;
      end else if (prog_done) begin
        busy <= 1'b0;
        for (int i = 0; i < PAGE_BYTES; i++)
          if (vmask[i])
            mem[STORE_W'(store_index(int'(page_base[STORE_PAGE_W-1:0]), i, PAGE_W))] <= pbuf[i];
      end else if (busy) begin
        prog_cnt <= prog_cnt + 1'b1;
      end
    end
  end

  // R5
  foreign_page_keeps_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_reject |=> $stable(page_base));
  // R6
  prog_follows_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(loading));
  // R7
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !prog_done) |=> busy);
  // R7
  no_load_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !loading);
endmodule

// File: rtl/pbee_ctrl.sv
module pbee_ctrl
  import pbee_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int PAGE_W       = 8,
  parameter int STORE_PAGE_W = 2,
  parameter int LOAD_WIN     = 25000,
  parameter int PROG_CYC     = 1250000,
  parameter int MIN_LOW      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vcc_ok,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  output logic              busy
);
  localparam int AGE_W   = cnt_width(LOAD_WIN);
  localparam int STORE_W = STORE_PAGE_W + PAGE_W;

  logic [3:0]        ctl_s;
  logic              ce_ns, oe_ns, we_ns, vcc_s;
  logic [ADDR_W-1:0] addr_a;
  byte_t             data_a;

  // Controls synchronized; reset state is "deselected, supply low".
  pbee_sync #(.W(4), .RST_VAL(4'b0111)) i_ctl_sync (
    .clk(clk), .rst_n(rst_n), .d({vcc_ok, we_n, oe_n, ce_n}), .q(ctl_s));
  assign {vcc_s, we_ns, oe_ns, ce_ns} = ctl_s;

  // Address and data delayed to stay aligned with the synchronized controls.
  pbee_sync #(.W(ADDR_W + DATA_W), .RST_VAL('0)) i_bus_align (
    .clk(clk), .rst_n(rst_n), .d({addr, dq_i}), .q({addr_a, data_a}));

  logic              wr_act, wr_start, wr_done;
  logic [ADDR_W-1:0] wr_addr;
  byte_t             wr_data;
  logic [AGE_W-1:0]  wr_age;

  pbee_wrcap #(.ADDR_W(ADDR_W), .MIN_LOW(MIN_LOW), .LOAD_WIN(LOAD_WIN), .AGE_W(AGE_W)) i_wrcap (
    .clk(clk), .rst_n(rst_n), .ce_ns(ce_ns), .oe_ns(oe_ns), .we_ns(we_ns), .vcc_s(vcc_s),
    .addr_a(addr_a), .data_a(data_a), .wr_act(wr_act), .wr_start(wr_start),
    .wr_done(wr_done), .wr_addr(wr_addr), .wr_data(wr_data), .wr_age(wr_age));

  byte_t rd_byte;

  pbee_page #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .STORE_PAGE_W(STORE_PAGE_W),
              .LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC), .AGE_W(AGE_W), .STORE_W(STORE_W)) i_page (
    .clk(clk), .rst_n(rst_n), .wr_act(wr_act), .wr_done(wr_done), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_age(wr_age), .rd_idx(addr_a[STORE_W-1:0]), .rd_byte(rd_byte),
    .busy(busy));

  logic rd_cond;
  assign rd_cond = !ce_ns && !oe_ns && vcc_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_oe <= 1'b0;
      dq_o  <= '0;
    end else begin
      dq_oe <= rd_cond;
      dq_o  <= rd_cond ? rd_byte : '0;
    end
  end

  // R1
  drive_only_when_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> $past(!ce_ns && !oe_ns && vcc_s));
  // R9
  no_write_without_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> vcc_s);
endmodule

// File: tb/test_pbee_ctrl.sv
`timescale 1ns/1ps
module test_pbee_ctrl;
  localparam int ADDR_W = 17;
  localparam int LWIN   = 40;
  localparam int PCYC   = 60;
  localparam int MLOW   = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              vcc_ok = 1'b1;
  logic              ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        dq_i = '0;
  logic [7:0]        dq_o;
  logic              dq_oe, busy;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  pbee_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(8), .STORE_PAGE_W(2), .LOAD_WIN(LWIN),
              .PROG_CYC(PCYC), .MIN_LOW(MLOW)) i_pbee_ctrl (
    .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe), .busy(busy));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_we(input logic [ADDR_W-1:0] a, input logic [7:0] d, input int len);
    @(negedge clk); ce_n = 1'b0; addr = a; dq_i = d;
    cyc(1); we_n = 1'b0;
    cyc(len); we_n = 1'b1;
    cyc(2); ce_n = 1'b1;
    cyc(1);
  endtask

  task automatic rd_chk(input logic [ADDR_W-1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; addr = a;
    cyc(6);
    chk(dq_oe && dq_o == exp, req, $sformatf("read @%0h", a), {dq_oe, dq_o}, {1'b1, exp});
    oe_n = 1'b1; ce_n = 1'b1;
    cyc(4);
  endtask

  // Waits for busy to rise, then returns how many cycles it stayed high (-1 if never).
  task automatic commit(output int len);
    int w = 0;
    len = -1;
    while (!busy && w < 200) begin cyc(1); w++; end
    if (busy) begin
      len = 0;
      while (busy && len < 1000) begin len++; cyc(1); end
    end
  endtask

  task automatic t_reset;
    cyc(3);
    chk(busy == 1'b0, "R10", "busy after reset", busy, 0);
    chk(dq_oe == 1'b0, "R10", "dq_oe after reset", dq_oe, 0);
  endtask

  task automatic t_read_float;
    rd_chk(17'h00010, 8'hFF, "R1");
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; cyc(5);
    chk(dq_oe == 1'b0, "R1", "float with oe_n high", dq_oe, 0);
    ce_n = 1'b1; oe_n = 1'b0; cyc(5);
    chk(dq_oe == 1'b0, "R1", "float with ce_n high", dq_oe, 0);
    oe_n = 1'b1; cyc(3);
  endtask

  task automatic t_single;
    int w = 0;
    int len;
    wr_we(17'h00105, 8'hA5, 4);
    cyc(10);
    chk(busy == 1'b0, "R6", "busy early in window", busy, 0);
    while (!busy && w < 60) begin cyc(1); w++; end
    chk(busy == 1'b1, "R6", "programming after window", busy, 1);
    len = 0;
    while (busy && len < 1000) begin len++; cyc(1); end
    chk(len == PCYC, "R7", "busy length", len, PCYC);
    rd_chk(17'h00105, 8'hA5, "R2");
  endtask

  task automatic t_retrigger;
    int len;
    logic [7:0] offs [5] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'hFF};
    for (int k = 0; k < 5; k++) begin
      if (k > 0) chk(busy == 1'b0, "R6", "load kept open", busy, 0);
      wr_we({9'h002, offs[k]}, 8'h10 + 8'(k), 4);
      if (k < 4) cyc(22);
    end
    commit(len);
    chk(len == PCYC, "R4", "one programming cycle", len, PCYC);
    for (int k = 0; k < 5; k++) rd_chk({9'h002, offs[k]}, 8'h10 + 8'(k), "R4");
    rd_chk(17'h00204, 8'hFF, "R4");
  endtask

  task automatic t_foreign;
    int len;
    wr_we(17'h00340, 8'h11, 4);
    cyc(14);
    wr_we(17'h00150, 8'h22, 4);
    cyc(26);
    chk(busy == 1'b1, "R5", "window not restarted", busy, 1);
    commit(len);
    rd_chk(17'h00340, 8'h11, "R5");
    rd_chk(17'h00150, 8'hFF, "R5");
  endtask

  task automatic t_ce_ctl;
    int len;
    @(negedge clk); we_n = 1'b0; addr = 17'h00120; dq_i = 8'h81;
    cyc(2); addr = 17'h00110; ce_n = 1'b0;
    cyc(3); dq_i = 8'h3C;
    cyc(2); ce_n = 1'b1;
    cyc(2); we_n = 1'b1;
    cyc(1);
    commit(len);
    rd_chk(17'h00110, 8'h3C, "R3");
    rd_chk(17'h00120, 8'hFF, "R3");
  endtask

  task automatic t_oe_block;
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0; addr = 17'h00060; dq_i = 8'h99;
    cyc(5); we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    cyc(60);
    chk(busy == 1'b0, "R2", "no programming with oe_n low", busy, 0);
    rd_chk(17'h00060, 8'hFF, "R2");
  endtask

  task automatic t_glitch;
    int len;
    wr_we(17'h00070, 8'h5A, MLOW - 1);
    cyc(60);
    chk(busy == 1'b0, "R8", "short pulse ignored", busy, 0);
    rd_chk(17'h00070, 8'hFF, "R8");
    wr_we(17'h00071, 8'h6B, MLOW);
    commit(len);
    chk(len == PCYC, "R8", "minimum pulse accepted", len, PCYC);
    rd_chk(17'h00071, 8'h6B, "R8");
  endtask

  task automatic t_busy_ignore;
    int w = 0;
    wr_we(17'h003A0, 8'hC3, 4);
    while (!busy && w < 200) begin cyc(1); w++; end
    wr_we(17'h000B0, 8'h44, 4);
    w = 0;
    while (busy && w < 200) begin cyc(1); w++; end
    cyc(60);
    chk(busy == 1'b0, "R7", "write during busy opened no load", busy, 0);
    rd_chk(17'h003A0, 8'hC3, "R7");
    rd_chk(17'h000B0, 8'hFF, "R7");
  endtask

  task automatic t_vcc;
    @(negedge clk); vcc_ok = 1'b0; cyc(4);
    ce_n = 1'b0; oe_n = 1'b0; addr = 17'h00105; cyc(6);
    chk(dq_oe == 1'b0, "R9", "no drive with supply low", dq_oe, 0);
    ce_n = 1'b1; oe_n = 1'b1; cyc(3);
    wr_we(17'h000C0, 8'h12, 4);
    cyc(60);
    chk(busy == 1'b0, "R9", "no programming with supply low", busy, 0);
    vcc_ok = 1'b1; cyc(4);
    rd_chk(17'h000C0, 8'hFF, "R9");
    rd_chk(17'h00105, 8'hA5, "R9");
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    t_reset();
    t_read_float();
    t_single();
    t_retrigger();
    t_foreign();
    t_ce_ctl();
    t_oe_block();
    t_glitch();
    t_busy_ignore();
    t_vcc();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule